// File: doc/BRIEF.md
# Receive Byte-Packing FIFO with Fill Thresholds

This block sits between a serial receive engine and a register bus. The engine delivers received bytes one at a time and the block stores up to 64 of them. A single data-port read takes up to four bytes and packs them into one 32-bit word, with the oldest byte in the lowest lane.

The block reports its fill level in a 12-bit status word: a byte count, an empty flag, a general ready flag and three threshold flags for 16, 32 and 64 bytes. It also drives three interrupt status bits. A write to the flush register discards the contents. A configuration bit selects continuous mode, in which any held byte is reported as ready.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset the FIFO is empty. The status word is 0x800 and all three interrupt bits are 0.
- R2: A byte presented with `in_valid` is stored. Status bits 10:4 hold the number of buffered bytes, and status bit 11 is 1 exactly when that number is zero.
- R3: A data-port read returns min(4, count) bytes. The oldest byte is in bits 7:0 and each later byte is in the next higher lane. Lanes with no byte read as zero, and the bytes taken are removed.
- R4: Status bit 0 (ready) is 1 when at least four bytes are held. It is also 1 when a transfer-end pulse has been seen and a nonzero remainder is held. The end indication is cleared when the FIFO is emptied by a read or by a flush.
- R5: Status bits 1, 2 and 3 are 1 when at least 16, 32 and 64 bytes are held.
- R6: A byte that arrives while 64 bytes are held is discarded, and the count stays at 64.
- R7: A data-port read while the FIFO is empty returns zero and sets interrupt bit 0 (underrun). That bit stays set until `irq_ack[0]` is pulsed.
- R8: A flush write with `flush_bit` = 1 empties the FIFO, and a flush write with `flush_bit` = 0 has no effect.
- R9: Interrupt bit 1 is 1 while the FIFO is not empty, and interrupt bit 2 follows status bit 0.
- R10: When configuration bit 0 (continuous mode) is 1, status bit 0 is 1 whenever at least one byte is held.
- R11: A byte push and a data-port read in the same cycle both take effect. The read takes its bytes from the contents held before the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| xfer_done | input | 1 | Pulse marking the end of the receive transfer |
| rd_pop | input | 1 | Data-port read strobe |
| rd_word | output | 32 | Packed read data, valid in the cycle of `rd_pop` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cont | input | 1 | Continuous-mode value written by `cfg_we` |
| flush_we | input | 1 | Flush register write strobe |
| flush_bit | input | 1 | Bit 0 of the flush write |
| irq_ack | input | 3 | Write-one-to-clear for the interrupt bits (only bit 0 is sticky) |
| fifo_stat | output | 12 | Status: ready, three thresholds, count, empty |
| irq_stat | output | 3 | Interrupt status: underrun, not-empty, ready |

## Verification
The bench fills the FIFO up to the 64-byte boundary and then pushes one byte more. A design that lets that byte through would corrupt the oldest data, and a design that drops it incorrectly would report the wrong count. Earlier traffic leaves the read pointer at a non-zero offset, so a wrong wrap shows up as misordered bytes. Partial final words are read after a transfer-end pulse; a design that left the wrong bytes in the upper lanes, or that failed to raise ready for a remainder, would return a bad word or a low ready flag. Reads from an empty FIFO, flush writes with the bit clear, and a push and read in the same cycle check that nothing is lost, counted twice or cleared too early.

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo #(
  parameter int DEPTH = 64,
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              xfer_done,
  input  logic              rd_pop,
  output logic [8*LANES-1:0] rd_word,
  input  logic              cfg_we,
  input  logic              cfg_cont,
  input  logic              flush_we,
  input  logic              flush_bit,
  input  logic [2:0]        irq_ack,
  output logic [11:0]       fifo_stat,
  output logic [2:0]        irq_stat
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, take, cnt_nxt;
  logic          done_q, cont_q, und_q;
  logic          flush, push, rdy;

  assign flush = flush_we && flush_bit;
  assign push  = in_valid && (cnt < CW'(DEPTH));
  assign take  = rd_pop ? ((cnt >= CW'(LANES)) ? CW'(LANES) : cnt) : '0;
  assign cnt_nxt = cnt - take + CW'(push);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign rd_word[8*g +: 8] = (CW'(g) < cnt && rd_pop) ? mem[AW'(rptr + AW'(g))] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) if (push) mem[wptr] <= in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
      done_q <= 1'b0; cont_q <= 1'b0; und_q <= 1'b0;
    end else begin
      if (cfg_we) cont_q <= cfg_cont;
      if (flush) begin
        wptr <= '0; rptr <= '0; cnt <= '0; done_q <= 1'b0;
      end else begin
        if (push) wptr <= wptr + 1'b1;
        rptr <= rptr + AW'(take);
        cnt  <= cnt_nxt;
        if (xfer_done) done_q <= 1'b1;
        else if (take != '0 && cnt_nxt == '0) done_q <= 1'b0;
      end
      if (rd_pop && cnt == '0) und_q <= 1'b1;
      else if (irq_ack[0]) und_q <= 1'b0;
    end
  end

  assign rdy = (cnt >= CW'(LANES)) || (cnt != '0 && (done_q || cont_q));
  assign fifo_stat = {cnt == '0, 7'(cnt), cnt >= CW'(64), cnt >= CW'(32), cnt >= CW'(16), rdy};
  assign irq_stat  = {rdy, cnt != '0, und_q};

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && in_valid && !rd_pop && !flush) |=> $stable(fifo_stat));
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fifo_stat[11] && !flush) |-> (rd_word == '0) ##1 irq_stat[0]);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_stat[11] && !irq_stat[1]);
  // R2
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fifo_stat[3] && !rd_pop && !flush) |=> fifo_stat[10:4] == $past(fifo_stat[10:4]) + 7'd1);
  // R9
  irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat[2] == fifo_stat[0] && irq_stat[1] == !fifo_stat[11]);
endmodule

// File: tb/rx_pack_fifo_tb_top.sv
module rx_pack_fifo_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, xfer_done = 0, rd_pop = 0, cfg_we = 0, cfg_cont = 0;
  logic flush_we = 0, flush_bit = 0;
  logic [7:0] in_byte = 0;
  logic [2:0] irq_ack = 0;
  logic [31:0] rd_word;
  logic [11:0] fifo_stat;
  logic [2:0] irq_stat;

  int checks = 0, fails = 0;
  bit finished = 0;
  byte unsigned q[$];
  bit done_m = 0, cont_m = 0, und_m = 0;

  always #10 clk = ~clk;

  rx_pack_fifo dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .xfer_done(xfer_done), .rd_pop(rd_pop), .rd_word(rd_word), .cfg_we(cfg_we),
    .cfg_cont(cfg_cont), .flush_we(flush_we), .flush_bit(flush_bit), .irq_ack(irq_ack),
    .fifo_stat(fifo_stat), .irq_stat(irq_stat));

  function automatic logic [11:0] exp_stat();
    int n = q.size();
    logic r = (n >= 4) || (n != 0 && (done_m || cont_m));
    return {n == 0, 7'(n), n >= 64, n >= 32, n >= 16, r};
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 4 && i < q.size(); i++) w[8*i +: 8] = q[i];
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_stat(string tag);
    chk({tag, " stat"}, 32'(fifo_stat), 32'(exp_stat()));
    chk({tag, " irq"}, 32'(irq_stat), 32'({exp_stat() & 12'h1 ? 1'b1 : 1'b0, q.size() != 0, und_m}));
  endtask

  task automatic push(byte unsigned b);
    in_valid = 1; in_byte = b;
    @(negedge clk); in_valid = 0;
    if (q.size() < 64) q.push_back(b);
  endtask

  task automatic model_pop();
    if (q.size() == 0) und_m = 1;
    for (int i = 0; i < 4 && q.size() > 0; i++) void'(q.pop_front());
  endtask

  task automatic pop(string tag);
    rd_pop = 1; #1;
    chk(tag, rd_word, exp_word());
    @(negedge clk); rd_pop = 0;
    model_pop();
    if (q.size() == 0) done_m = 0;
  endtask

  task automatic flush_all(bit b);
    flush_we = 1; flush_bit = b;
    @(negedge clk); flush_we = 0; flush_bit = 0;
    if (b) begin q.delete(); done_m = 0; end
  endtask

  task automatic t_reset();
    chk_stat("R1 reset");
    chk("R1 reset raw", 32'(fifo_stat), 32'h800);
  endtask

  task automatic t_word();
    push(8'h11); push(8'h22); push(8'h33);
    chk_stat("R2 count3");
    push(8'h44);
    chk_stat("R4 four bytes ready");
    pop("R3 full word");
    chk_stat("R2 empty after read");
  endtask

  task automatic t_partial();
    push(8'hAA); push(8'hBB); push(8'hCC);
    chk_stat("R4 remainder not ready");
    xfer_done = 1; @(negedge clk); xfer_done = 0; done_m = 1;
    chk_stat("R4 remainder after end");
    pop("R3 zero-filled partial");
    chk_stat("R4 end cleared on empty");
  endtask

  task automatic t_thresh();
    for (int i = 0; i < 65; i++) begin
      push(byte'(i + 8'h40));
      if (i == 15 || i == 31) chk_stat("R5 threshold");
    end
    chk_stat("R6 full drop and R5 64");
    chk("R6 count held", 32'(fifo_stat[10:4]), 32'd64);
    for (int i = 0; i < 16; i++) pop("R3 wrap order");
    chk_stat("R2 drained");
  endtask

  task automatic t_underrun();
    pop("R7 empty read zero");
    chk_stat("R7 underrun set");
    @(negedge clk);
    chk_stat("R7 underrun sticky");
    irq_ack = 3'b001; @(negedge clk); irq_ack = 0; und_m = 0;
    chk_stat("R7 underrun acked");
  endtask

  task automatic t_flush();
    for (int i = 0; i < 10; i++) push(byte'(i));
    flush_all(0);
    chk_stat("R8 flush bit clear ignored");
    flush_all(1);
    chk_stat("R8 flush empties");
  endtask

  task automatic t_cont();
    cfg_we = 1; cfg_cont = 1; @(negedge clk); cfg_we = 0; cont_m = 1;
    push(8'h5A);
    chk_stat("R10 cont one byte ready");
    cfg_we = 1; cfg_cont = 0; @(negedge clk); cfg_we = 0; cont_m = 0;
    chk_stat("R10 cont off not ready");
    pop("R3 single byte");
  endtask

  task automatic t_simul();
    push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05);
    in_valid = 1; in_byte = 8'h06; rd_pop = 1; #1;
    chk("R11 read during push", rd_word, exp_word());
    @(negedge clk); in_valid = 0; rd_pop = 0;
    model_pop(); q.push_back(8'h06);
    chk_stat("R11 count after both");
    xfer_done = 1; @(negedge clk); xfer_done = 0; done_m = 1;
    pop("R11 remaining pair");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset(); t_word(); t_partial(); t_thresh();
    t_underrun(); t_flush(); t_cont(); t_simul();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule